// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port attached to a simple byte-wide register bus. Each pin has a direction bit and an output data bit. The block drives the pin values and their output enables. It also samples the pin inputs through a synchronizer of configurable depth, two flops by default.

Data accesses go through an address window in which eight address bits act as a per-pin mask. A single bus write can therefore set or clear any subset of pins. A single read returns only the selected pins. Neither needs a read-modify-write sequence. A pin configured as an input ignores data writes, so software must write its value again after turning the pin into an output.

Read data is registered and returned one cycle after the request, flagged by a valid strobe.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the direction and output data registers are 0, so `pin_oe_o` = 0x00, `pin_o` = 0x00 and `rvalid_o` = 0.
- R2: Offset 0x400 holds the direction register, which can be read and written. Bit n = 1 makes pin n an output, and `pin_oe_o` equals this register.
- R3: A write to the data window (`addr_i[11:10]` = 0, `addr_i[1:0]` = 0) uses `addr_i[n+2]` as the mask bit for pin n. Only output pins with mask bit 1 take `wdata_i[n]`. All other `pin_o` bits keep their previous value.
- R4: A data write has no effect on a pin whose direction bit is 0. When that pin later becomes an output, it drives the value it held before the write.
- R5: On a data read, every bit whose mask bit is 0 returns 0.
- R6: On a data read, a selected output pin returns its driven value `pin_o[n]`, whatever level is present on `pin_i[n]`.
- R7: On a data read, a selected input pin returns `pin_i[n]` through a two-flop synchronizer. A read sampled at the first or second rising edge after `pin_i` changes returns the old level. A read sampled at the third edge returns the new level.
- R8: Any offset that is neither 0x400 nor a data-window address reads as 0, and writes to it change no register.
- R9: For a read request sampled at a rising edge, `rdata_o` is valid with `rvalid_o` = 1 after that edge. `rvalid_o` is 0 in every cycle that follows no read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| rvalid_o | output | 1 | Read data valid |
| pin_i | input | 8 | Pin input levels (asynchronous) |
| pin_o | output | 8 | Pin output values |
| pin_oe_o | output | 8 | Pin output enables |

## Verification
A wrong direction bit shows on `pin_oe_o` in the cycle after the write. It also shows as the wrong source on the next data read. A corrupted output bit shows on `pin_o` at once, and it may come from a masked-off pin or from a pin set as an input. A synchronizer that is too short or too long shows as a read one edge early or late relative to a `pin_i` change. Each such fault therefore reaches the ports within one to three cycles of the stimulus that exposes it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PIN_N   = 8;
  localparam int ADDR_W  = 12;
  localparam logic [ADDR_W-1:0] DIR_OFS = 12'h400;

  typedef struct packed {
    logic             data_hit;
    logic             dir_hit;
    logic [PIN_N-1:0] mask;
  } dec_t;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o.dir_hit  = (addr_i == DIR_OFS);
    dec_o.data_hit = (addr_i[ADDR_W-1:PIN_N+2] == '0) && (addr_i[1:0] == 2'b00);
    dec_o.mask     = addr_i[PIN_N+1:2];
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_dir_i,
  input  logic             wr_data_i,
  input  logic [PIN_N-1:0] mask_i,
  input  logic [PIN_N-1:0] wdata_i,
  output logic [PIN_N-1:0] dir_o,
  output logic [PIN_N-1:0] out_o
);
  logic [PIN_N-1:0] dir_q, out_q, upd;

  // input pins ignore data writes
  assign upd = mask_i & dir_q & {PIN_N{wr_data_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir_i) dir_q <= wdata_i;
      out_q <= (out_q & ~upd) | (wdata_i & upd);
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;

  // R2
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir_i |=> $stable(dir_q));
  // R3
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_data_i |=> $stable(out_q));
  // R3
  mask_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i |=> ((out_q ^ $past(out_q)) & ~$past(mask_i)) == '0);
  // R4
  input_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i |=> ((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0);
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_pkg::*;
(
  input  dec_t             dec_i,
  input  logic [PIN_N-1:0] dir_i,
  input  logic [PIN_N-1:0] out_i,
  input  logic [PIN_N-1:0] sync_i,
  output logic [PIN_N-1:0] rdata_o
);
  logic [PIN_N-1:0] level;

  for (genvar n = 0; n < PIN_N; n++) begin : g_pin
    assign level[n] = dir_i[n] ? out_i[n] : sync_i[n];
  end

  always_comb begin
    if (dec_i.dir_hit)       rdata_o = dir_i;
    else if (dec_i.data_hit) rdata_o = level & dec_i.mask;
    else                     rdata_o = '0;
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PIN_N-1:0]  wdata_i,
  output logic [PIN_N-1:0]  rdata_o,
  output logic              rvalid_o,
  input  logic [PIN_N-1:0]  pin_i,
  output logic [PIN_N-1:0]  pin_o,
  output logic [PIN_N-1:0]  pin_oe_o
);
  dec_t             dec;
  logic [PIN_N-1:0] dir, out, sync, rd_d;
  logic             rd_req, wr_req;

  assign rd_req = req_i & ~we_i;
  assign wr_req = req_i &  we_i;

  gpio_addr_dec u_dec (.addr_i(addr_i), .dec_o(dec));

  gpio_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync));

  gpio_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_dir_i(wr_req & dec.dir_hit), .wr_data_i(wr_req & dec.data_hit),
    .mask_i(dec.mask), .wdata_i(wdata_i), .dir_o(dir), .out_o(out));

  gpio_rd_mux u_mux (
    .dec_i(dec), .dir_i(dir), .out_i(out), .sync_i(sync), .rdata_o(rd_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_req;
      if (rd_req) rdata_o <= rd_d;
    end
  end

  assign pin_o    = out;
  assign pin_oe_o = dir;

  // R9
  rvalid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);
  // R9
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rvalid_o);
  // R5
  rd_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && dec.data_hit) |=> (rdata_o & ~$past(dec.mask)) == '0);
  // R8
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !dec.data_hit && !dec.dir_hit) |=> rdata_o == '0);
  // R6
  out_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && dec.data_hit) |=>
      ((rdata_o ^ $past(pin_o)) & $past(pin_oe_o) & $past(dec.mask)) == '0);
endmodule

// File: tb/tb_gpio_mask_port.sv
`timescale 1ns/1ps
module tb_gpio_mask_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0, pin_in = '0;
  logic [7:0]  rdata, pin_out, pin_oe;
  logic        rvalid;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  gpio_mask_port dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .pin_i(pin_in),
    .pin_o(pin_out), .pin_oe_o(pin_oe));

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [7:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R9 unexpected rvalid actual=%h expected=none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic run_test;
    repeat (3) @(negedge clk);
    check("R1 pin_o", pin_out, 8'h00);
    check("R1 pin_oe_o", pin_oe, 8'h00);
    check("R1 rvalid", {7'd0, rvalid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(12'h400, 8'h00, "R1 dir read");

    bus_write(12'h400, 8'h0F);
    check("R2 pin_oe_o", pin_oe, 8'h0F);
    bus_read(12'h400, 8'h0F, "R2 dir read");

    bus_write(12'h3FC, 8'hFF);
    check("R4 input pins ignore write", pin_out, 8'h0F);
    bus_write(12'h008, 8'h00);
    check("R3 single pin clear", pin_out, 8'h0D);
    bus_write(12'h018, 8'hFF);
    check("R3 two pin set", pin_out, 8'h0F);
    bus_write(12'h004, 8'hFE);
    check("R3 pin0 clear", pin_out, 8'h0E);
    check("R9 no rvalid after write", {7'd0, rvalid}, 8'h00);

    bus_write(12'h400, 8'hFF);
    check("R4 old value after dir switch", pin_out, 8'h0E);
    bus_write(12'h3FC, 8'hA5);
    check("R3 full write", pin_out, 8'hA5);

    pin_in = 8'h5A;
    repeat (3) @(negedge clk);
    bus_read(12'h3FC, 8'hA5, "R6 output read");
    bus_read(12'h03C, 8'h05, "R5 masked read");

    bus_write(12'h400, 8'h0F);
    bus_read(12'h3FC, 8'h55, "R7 mixed read");
    bus_read(12'h100, 8'h40, "R7 single input pin");
    bus_read(12'h200, 8'h00, "R5 single pin zero");

    // synchronizer latency: change and read sampled at edges 1,2,3
    pin_in = 8'h00;
    bus_read(12'h3FC, 8'h55, "R7 edge1 old");
    bus_read(12'h3FC, 8'h55, "R7 edge2 old");
    bus_read(12'h3FC, 8'h05, "R7 edge3 new");

    bus_write(12'h404, 8'hFF);
    bus_write(12'h3FD, 8'h00);
    bus_write(12'h800, 8'h00);
    check("R8 pin_o after unmapped writes", pin_out, 8'hA5);
    check("R8 pin_oe_o after unmapped writes", pin_oe, 8'h0F);
    bus_read(12'h400, 8'h0F, "R8 dir intact");
    bus_read(12'h404, 8'h00, "R8 read 0x404");
    bus_read(12'h3FD, 8'h00, "R8 read 0x3FD");
    bus_read(12'hC00, 8'h00, "R8 read 0xC00");
    repeat (2) @(negedge clk);
    check("R9 rvalid idle", {7'd0, rvalid}, 8'h00);
    check("R9 scoreboard drained", exp_q.size(), 8'd0);
  endtask

  initial begin
    fork
      run_test();
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule